// File: doc/BRIEF.md
# Packet FIFO mode controller

This block is the control-and-sequencing logic around a packet transceiver's transmit and receive FIFOs. A byte-wide mode word is written and read through a simple register port. The FIFO storage and the radio datapath sit elsewhere. This block watches their status lines and reports whether the radio should be idle, transmitting or receiving. It also issues one-cycle clear pulses to either FIFO.

Transmission can start on its own once the transmit FIFO fills to its almost-full mark, and it ends when the FIFO drains. Reception is started by a request strobe or by a wake-up timer tick in low-duty-cycle mode. It ends after the first good packet, or it keeps collecting packets when multi-packet mode is set. A wake-up session in low-duty-cycle mode is held open for a programmed minimum number of cycles. It is held open longer while a packet is still arriving. The three-bit antenna-selection field is only stored and returned on reads.

Top module: `pkt_fifo_mode_ctrl`

## Requirements
- R1: Reset is synchronous and active high. After reset the mode word reads 0x00, the state output is idle (encoding 2'b00), and both clear pulses are low. The state encodings are idle 2'b00, transmit 2'b01 and receive 2'b10.
- R2: A read returns the last written mode word, including both clear bits and the antenna field in bits [7:5]. The other fields are: bit 4 multi-packet receive, bit 3 auto-transmit, bit 2 low-duty-cycle enable, bit 1 receive-FIFO clear, bit 0 transmit-FIFO clear.
- R3: A write that takes bit 0 from 1 to 0 makes clr_tx high for exactly the one cycle after the write edge. A write that takes bit 1 from 1 to 0 does the same on clr_rx. Both pulses can occur together.
- R4: A write that leaves a clear bit at 1, sets it to 1, or writes 0 to an already-0 clear bit produces no pulse.
- R5: In idle with auto-transmit set and tx_almost_full high, the state is transmit one cycle later. This takes priority over a receive request in the same cycle. With auto-transmit clear, almost-full is ignored.
- R6: In transmit, the state returns to idle one cycle after tx_empty is high, and not before. Clearing auto-transmit during transmit does not end it.
- R7: In idle, rx_start moves the state to receive one cycle later. With multi-packet clear, one pkt_valid pulse returns the state to idle one cycle later.
- R8: With multi-packet set, the state stays in receive across any number of pkt_valid pulses.
- R9: In idle with low-duty-cycle set, a wake_tick moves the state to receive and loads min_on_cycles = N. The state then stays receive for N+1 cycles and returns to idle, while rx_busy is low.
- R10: If rx_busy is high when the minimum on-time runs out, receive is held until rx_busy drops. Idle follows one cycle after it drops.
- R11: With low-duty-cycle clear, wake_tick has no effect and the state stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Mode word write strobe |
| wr_data | input | 8 | Mode word write value |
| rd_data | output | 8 | Current mode word |
| tx_almost_full | input | 1 | Transmit FIFO at almost-full mark |
| tx_empty | input | 1 | Transmit FIFO empty |
| pkt_valid | input | 1 | One-cycle pulse: a good packet was received |
| rx_busy | input | 1 | A packet reception is in progress |
| rx_start | input | 1 | Request to enter receive |
| wake_tick | input | 1 | Wake-up timer period tick |
| min_on_cycles | input | 16 | Minimum on-time of a wake session, in cycles |
| state | output | 2 | Radio state: 00 idle, 01 transmit, 10 receive |
| clr_tx | output | 1 | One-cycle transmit FIFO clear pulse |
| clr_rx | output | 1 | One-cycle receive FIFO clear pulse |

## Verification
Every result is one register away from its cause. The mode word, both clear pulses and each state change show up in the cycle after the edge that captured the write or the status input. A wake session of N is the exception: it keeps receive for N+1 cycles after the tick edge. The bench drives inputs on the falling edge and samples on the next falling edge, so each check lands in the cycle the result is due. For the on-time window, the bench counts exactly N further edges, checks that receive still holds, then checks idle after one more edge.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_TX   = 2'b01,
    ST_RX   = 2'b10
  } pfm_state_e;

  // field positions inside the mode word
  localparam int BIT_CLR_TX = 0;
  localparam int BIT_CLR_RX = 1;
  localparam int BIT_LDC    = 2;
  localparam int BIT_AUTOTX = 3;
  localparam int BIT_MULTI  = 4;
  localparam int NUM_CLR    = 2;
endpackage

// File: rtl/pfm_ctrl_reg.sv
module pfm_ctrl_reg
  import pfm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [NUM_CLR-1:0] clr_q
);

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_en) ctrl_q <= wr_data;
  end

  // one falling-edge detector per clear bit; bit g of clr_q pulses for bit g
  for (genvar g = 0; g < NUM_CLR; g++) begin : g_clr
    always_ff @(posedge clk) begin
      if (rst) clr_q[g] <= 1'b0;
      else     clr_q[g] <= wr_en && ctrl_q[g] && !wr_data[g];
    end

    // R3: a clear pulse never lasts longer than one cycle
    p_clr_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
      clr_q[g] |=> !clr_q[g]);

    // R3/R4: a pulse only follows a 1-to-0 change of the stored bit
    p_clr_cause_r4: assert property (@(posedge clk) disable iff (rst)
      clr_q[g] |-> ($past(ctrl_q[g]) && !ctrl_q[g]));
  end

endmodule

// File: rtl/pfm_ontime_cnt.sv
module pfm_ontime_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                    cnt_q <= '0;
    else if (load)              cnt_q <= load_val;
    else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R9: once exhausted the counter stays at zero until reloaded
  p_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q == '0) |=> cnt_q == '0);

endmodule

// File: rtl/pfm_state_fsm.sv
module pfm_state_fsm
  import pfm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       autotx,
  input  logic       multi,
  input  logic       ldc_en,
  input  logic       tx_af,
  input  logic       tx_empty,
  input  logic       pkt_valid,
  input  logic       rx_busy,
  input  logic       rx_start,
  input  logic       wake_tick,
  input  logic       on_zero,
  output pfm_state_e state_q,
  output logic       cnt_load,
  output logic       cnt_run
);

  pfm_state_e nxt;
  logic       ldc_q;
  logic       single_done;

  assign single_done = pkt_valid && !multi;

  always_comb begin
    nxt      = state_q;
    cnt_load = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (autotx && tx_af) nxt = ST_TX;
        else if (rx_start)   nxt = ST_RX;
        else if (ldc_en && wake_tick) begin
          nxt      = ST_RX;
          cnt_load = 1'b1;
        end
      end
      ST_TX: if (tx_empty) nxt = ST_IDLE;
      ST_RX: begin
        if (single_done)                       nxt = ST_IDLE;
        else if (ldc_q && on_zero && !rx_busy) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ldc_q   <= 1'b0;
    end else begin
      state_q <= nxt;
      ldc_q   <= (nxt == ST_RX) && (cnt_load || (state_q == ST_RX && ldc_q));
    end
  end

  assign cnt_run = (state_q == ST_RX) && ldc_q;

  p_autotx_entry_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && autotx && tx_af) |=> state_q == ST_TX);

  p_tx_exit_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TX && tx_empty) |=> state_q == ST_IDLE);

  p_tx_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TX && !tx_empty) |=> state_q == ST_TX);

  p_single_exit_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RX && pkt_valid && !multi) |=> state_q == ST_IDLE);

  p_multi_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RX && multi && !ldc_q) |=> state_q == ST_RX);

  p_ldc_min_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RX && ldc_q && !on_zero && !single_done) |=> state_q == ST_RX);

  p_busy_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RX && ldc_q && rx_busy && !single_done) |=> state_q == ST_RX);

  p_tick_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !ldc_en && !rx_start && !(autotx && tx_af))
      |=> state_q == ST_IDLE);

endmodule

// File: rtl/pkt_fifo_mode_ctrl.sv
module pkt_fifo_mode_ctrl
  import pfm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tx_almost_full,
  input  logic              tx_empty,
  input  logic              pkt_valid,
  input  logic              rx_busy,
  input  logic              rx_start,
  input  logic              wake_tick,
  input  logic [CNT_W-1:0]  min_on_cycles,
  output logic [1:0]        state,
  output logic              clr_tx,
  output logic              clr_rx
);

  logic [DATA_W-1:0]  ctrl_q;
  logic [NUM_CLR-1:0] clr_q;
  pfm_state_e         st_q;
  logic               cnt_load;
  logic               cnt_run;
  logic               on_zero;

  pfm_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q),
    .clr_q   (clr_q)
  );

  pfm_ontime_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .run      (cnt_run),
    .load_val (min_on_cycles),
    .zero     (on_zero)
  );

  pfm_state_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .autotx    (ctrl_q[BIT_AUTOTX]),
    .multi     (ctrl_q[BIT_MULTI]),
    .ldc_en    (ctrl_q[BIT_LDC]),
    .tx_af     (tx_almost_full),
    .tx_empty  (tx_empty),
    .pkt_valid (pkt_valid),
    .rx_busy   (rx_busy),
    .rx_start  (rx_start),
    .wake_tick (wake_tick),
    .on_zero   (on_zero),
    .state_q   (st_q),
    .cnt_load  (cnt_load),
    .cnt_run   (cnt_run)
  );

  assign rd_data = ctrl_q;
  assign state   = st_q;
  assign clr_tx  = clr_q[BIT_CLR_TX];
  assign clr_rx  = clr_q[BIT_CLR_RX];

  // R2: the read port follows every accepted write one cycle later
  p_readback_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data == $past(wr_data));

endmodule

// File: tb/tb_pkt_fifo_mode_ctrl.sv
module tb_pkt_fifo_mode_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_data;
  logic        tx_almost_full = 1'b0;
  logic        tx_empty = 1'b0;
  logic        pkt_valid = 1'b0;
  logic        rx_busy = 1'b0;
  logic        rx_start = 1'b0;
  logic        wake_tick = 1'b0;
  logic [15:0] min_on_cycles = 16'd0;
  logic [1:0]  state;
  logic        clr_tx;
  logic        clr_rx;

  int checks = 0;
  int errors = 0;

  localparam logic [1:0] S_IDLE = 2'b00;
  localparam logic [1:0] S_TX   = 2'b01;
  localparam logic [1:0] S_RX   = 2'b10;

  always #10 clk = ~clk;   // 50 MHz

  pkt_fifo_mode_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .tx_almost_full(tx_almost_full), .tx_empty(tx_empty), .pkt_valid(pkt_valid),
    .rx_busy(rx_busy), .rx_start(rx_start), .wake_tick(wake_tick),
    .min_on_cycles(min_on_cycles), .state(state), .clr_tx(clr_tx), .clr_rx(clr_rx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 state", state, S_IDLE);
    chk("R1 clr_tx", clr_tx, 1'b0);
    chk("R1 clr_rx", clr_rx, 1'b0);
  endtask

  task automatic t_readback();
    wr(8'hA4);
    chk("R2 readback A4", rd_data, 8'hA4);
    wr(8'h5B);
    chk("R2 readback 5B", rd_data, 8'h5B);
    wr(8'h00);
    chk("R3 both clr_tx", clr_tx, 1'b1);
    chk("R3 both clr_rx", clr_rx, 1'b1);
    step();
    chk("R3 clr_tx one cycle", clr_tx, 1'b0);
    chk("R3 clr_rx one cycle", clr_rx, 1'b0);
  endtask

  task automatic t_clear_tx();
    wr(8'h01);
    chk("R4 set no clr_tx", clr_tx, 1'b0);
    chk("R2 clear bit read", rd_data, 8'h01);
    wr(8'h01);
    chk("R4 hold no clr_tx", clr_tx, 1'b0);
    wr(8'h00);
    chk("R3 clr_tx pulse", clr_tx, 1'b1);
    chk("R3 clr_rx quiet", clr_rx, 1'b0);
    step();
    chk("R3 clr_tx ends", clr_tx, 1'b0);
    wr(8'h00);
    chk("R4 zero again no clr_tx", clr_tx, 1'b0);
  endtask

  task automatic t_clear_rx();
    wr(8'h02);
    chk("R4 set no clr_rx", clr_rx, 1'b0);
    wr(8'h00);
    chk("R3 clr_rx pulse", clr_rx, 1'b1);
    chk("R3 clr_tx quiet", clr_tx, 1'b0);
    step();
    chk("R3 clr_rx ends", clr_rx, 1'b0);
  endtask

  task automatic t_autotx();
    tx_almost_full = 1'b1;
    step();
    chk("R5 almost-full ignored", state, S_IDLE);
    tx_almost_full = 1'b0;
    wr(8'h08);
    tx_almost_full = 1'b1;
    rx_start = 1'b1;
    step();
    tx_almost_full = 1'b0;
    rx_start = 1'b0;
    chk("R5 enter tx over rx", state, S_TX);
    wr(8'h00);
    step();
    chk("R6 tx kept after autotx cleared", state, S_TX);
    tx_empty = 1'b1;
    step();
    tx_empty = 1'b0;
    chk("R6 idle on empty", state, S_IDLE);
  endtask

  task automatic t_rx_single();
    rx_start = 1'b1;
    step();
    rx_start = 1'b0;
    chk("R7 enter rx", state, S_RX);
    step();
    chk("R7 rx held", state, S_RX);
    pkt_valid = 1'b1;
    step();
    pkt_valid = 1'b0;
    chk("R7 idle after packet", state, S_IDLE);
  endtask

  task automatic t_rx_multi();
    wr(8'h10);
    rx_start = 1'b1;
    step();
    rx_start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      pkt_valid = 1'b1;
      step();
      pkt_valid = 1'b0;
      chk("R8 rx stays after packet", state, S_RX);
    end
    wr(8'h00);
    pkt_valid = 1'b1;
    step();
    pkt_valid = 1'b0;
    chk("R7 single exit after mode change", state, S_IDLE);
  endtask

  task automatic t_ldc();
    min_on_cycles = 16'd5;
    wr(8'h04);
    wake_tick = 1'b1;
    step();
    wake_tick = 1'b0;
    chk("R9 wake enters rx", state, S_RX);
    repeat (5) step();
    chk("R9 rx held for minimum", state, S_RX);
    step();
    chk("R9 idle after minimum", state, S_IDLE);
  endtask

  task automatic t_ldc_busy();
    min_on_cycles = 16'd2;
    rx_busy = 1'b1;
    wake_tick = 1'b1;
    step();
    wake_tick = 1'b0;
    repeat (6) step();
    chk("R10 rx held while busy", state, S_RX);
    rx_busy = 1'b0;
    step();
    chk("R10 idle when busy drops", state, S_IDLE);
  endtask

  task automatic t_ldc_off();
    wr(8'h00);
    wake_tick = 1'b1;
    step();
    wake_tick = 1'b0;
    chk("R11 tick ignored", state, S_IDLE);
    step();
    chk("R11 still idle", state, S_IDLE);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    t_reset();
    rst = 1'b0;
    step();
    t_reset();
    t_readback();
    t_clear_tx();
    t_clear_rx();
    t_autotx();
    t_rx_single();
    t_rx_multi();
    t_ldc();
    t_ldc_busy();
    t_ldc_off();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule